// File: doc/BRIEF.md
# Tag-Renamed Operand Waiting Bank

This block holds a few instructions bound for one functional unit while their source operands are still being computed. The issue stage writes an instruction into a free slot and receives that slot's tag, which it uses to rename the instruction's destination. For each of the two sources, the issue stage supplies either a finished value or the tag of the slot that will produce it. A tag of zero means the value is already present. Slots are tagged `BASE_TAG` upward, so with the defaults they are tagged 1 to 4.

The bank watches a shared result broadcast. A slot waiting on a tag copies the broadcast data when that tag appears. A slot whose two sources are both present is offered to the execution unit. The lowest-numbered such slot is offered, one per cycle. A slot stays occupied after it is handed over. It returns to the free pool only when the broadcast carries its own tag.

Each slot is a four-state machine with states FREE, WAIT, READY and EXEC. The transitions are:
- ALLOC: FREE to WAIT, or FREE to READY when both sources are already present.
- WAKE: WAIT to READY.
- GRANT: READY to EXEC.
- RETIRE: EXEC to FREE.

Top module: `tag_station_bank`

## Requirements
- R1: On the first cycle after a synchronous reset, `iss_ready` is 1, `iss_tag_out` is `BASE_TAG` (1), and `disp_valid` is 0.
- R2: `iss_tag_out` always shows the tag of the lowest-numbered free slot. An issue with `iss_valid=1` and `iss_ready=1` occupies that slot at the clock edge.
- R3: `iss_ready` is 0 when every slot is occupied. An issue attempted while `iss_ready` is 0 changes no slot.
- R4: A source issued with tag 0 keeps the supplied value. A slot issued with both tags 0 is offered on `disp_*` in the cycle after issue.
- R5: A broadcast (`bus_valid=1`) whose `bus_tag` equals a waiting source tag loads `bus_data` into that source and marks it present. Broadcasts with other tags leave the source waiting.
- R6: If an issued source tag equals the tag broadcast in the same cycle, the source takes `bus_data` at issue and is present from the next cycle.
- R7: A slot is offered only when both sources are present. Among ready slots, the one with the lowest tag is offered, and only one slot is offered per cycle.
- R8: A slot handed over (`disp_valid=1` and `disp_ready=1`) is not offered again. While `disp_ready` is 0, the offer stays up.
- R9: A handed-over slot stays occupied until `bus_tag` equals its own tag with `bus_valid=1`. It is free in the next cycle. No slot frees without a broadcast.
- R10: A synchronous reset frees all slots and clears all source tags, so broadcasts after reset wake nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code to hold |
| iss_tag_a | input | TAG_W | Producer tag of source A, 0 if the value is given |
| iss_val_a | input | DATA_W | Value of source A when its tag is 0 |
| iss_tag_b | input | TAG_W | Producer tag of source B, 0 if the value is given |
| iss_val_b | input | DATA_W | Value of source B when its tag is 0 |
| iss_addr | input | ADDR_W | Address or immediate field |
| iss_ready | output | 1 | At least one slot is free |
| iss_tag_out | output | TAG_W | Tag of the slot the next issue takes |
| bus_valid | input | 1 | Result broadcast valid |
| bus_tag | input | TAG_W | Tag of the broadcast producer |
| bus_data | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | A ready slot is offered |
| disp_ready | input | 1 | Execution unit takes the offer |
| disp_tag | output | TAG_W | Tag of the offered slot |
| disp_op | output | OP_W | Operation of the offered slot |
| disp_val_a | output | DATA_W | Source A value of the offered slot |
| disp_val_b | output | DATA_W | Source B value of the offered slot |
| disp_addr | output | ADDR_W | Address field of the offered slot |

## Verification
A source that misses its wakeup leaves its slot in WAIT forever. At the ports this shows as `disp_valid` never rising for that tag, and in a full bank as `iss_ready` stuck low. A slot that leaks back to FREE early shows in `iss_tag_out` in the very next cycle. A wrong capture shows as a wrong `disp_val_a` or `disp_val_b` on the cycle the slot is offered. Ordering faults in the picker appear as an unexpected `disp_tag` in the first cycle where two slots are ready together.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2,
        ST_EXEC  = 2'd3
    } rs_state_e;
endpackage

// File: rtl/rs_pick_lowest.sv
module rs_pick_lowest #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
            end
        end
    end
    assign any = |req;
endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int OP_W   = 4,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter logic [TAG_W-1:0] MY_TAG = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_tag_a,
    input  logic [DATA_W-1:0] iss_val_a,
    input  logic [TAG_W-1:0]  iss_tag_b,
    input  logic [DATA_W-1:0] iss_val_b,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              grant,
    output logic              is_free,
    output logic              is_ready,
    output logic [OP_W-1:0]   op,
    output logic [DATA_W-1:0] val_a,
    output logic [DATA_W-1:0] val_b,
    output logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  q_a,
    output logic [TAG_W-1:0]  q_b
);
    rs_state_e state, state_nx;

    logic hit_a, hit_b, hit_ia, hit_ib;
    logic [TAG_W-1:0] q_a_nx, q_b_nx, iq_a, iq_b;

    // wakeup match for stored sources and for sources arriving at issue
    assign hit_a  = bus_valid && (q_a != '0) && (q_a == bus_tag);
    assign hit_b  = bus_valid && (q_b != '0) && (q_b == bus_tag);
    assign hit_ia = bus_valid && (iss_tag_a != '0) && (iss_tag_a == bus_tag);
    assign hit_ib = bus_valid && (iss_tag_b != '0) && (iss_tag_b == bus_tag);
    assign q_a_nx = hit_a  ? '0 : q_a;
    assign q_b_nx = hit_b  ? '0 : q_b;
    assign iq_a   = hit_ia ? '0 : iss_tag_a;
    assign iq_b   = hit_ib ? '0 : iss_tag_b;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FREE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FREE:  if (alloc) state_nx = (iq_a == '0 && iq_b == '0) ? ST_READY : ST_WAIT;
            ST_WAIT:  if (q_a_nx == '0 && q_b_nx == '0) state_nx = ST_READY;
            ST_READY: if (grant) state_nx = ST_EXEC;
            ST_EXEC:  if (bus_valid && bus_tag == MY_TAG) state_nx = ST_FREE;
            default:  state_nx = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_a   <= '0;
            q_b   <= '0;
            op    <= '0;
            val_a <= '0;
            val_b <= '0;
            addr  <= '0;
        end else if (state == ST_FREE && alloc) begin
            op    <= iss_op;
            addr  <= iss_addr;
            q_a   <= iq_a;
            q_b   <= iq_b;
            val_a <= hit_ia ? bus_data : iss_val_a;
            val_b <= hit_ib ? bus_data : iss_val_b;
        end else if (state == ST_WAIT) begin
            q_a <= q_a_nx;
            q_b <= q_b_nx;
            if (hit_a) val_a <= bus_data;
            if (hit_b) val_b <= bus_data;
        end
    end

    always_comb begin
        is_free  = 1'b0;
        is_ready = 1'b0;
        unique case (state)
            ST_FREE:  is_free  = 1'b1;
            ST_READY: is_ready = 1'b1;
            ST_WAIT, ST_EXEC: ;
            default:  ;
        endcase
    end
endmodule

// File: rtl/tag_station_bank.sv
module tag_station_bank #(
    parameter int N        = 4,
    parameter int OP_W     = 4,
    parameter int TAG_W    = 3,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 16,
    parameter int BASE_TAG = 1,
    localparam int IDX_W   = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_tag_a,
    input  logic [DATA_W-1:0] iss_val_a,
    input  logic [TAG_W-1:0]  iss_tag_b,
    input  logic [DATA_W-1:0] iss_val_b,
    input  logic [ADDR_W-1:0] iss_addr,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag_out,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [TAG_W-1:0]  disp_tag,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_val_a,
    output logic [DATA_W-1:0] disp_val_b,
    output logic [ADDR_W-1:0] disp_addr
);
    logic [N-1:0]     free_vec, ready_vec, alloc_gnt, disp_gnt;
    logic [IDX_W-1:0] alloc_idx, disp_idx;
    logic [OP_W-1:0]   op_arr  [N];
    logic [DATA_W-1:0] va_arr  [N];
    logic [DATA_W-1:0] vb_arr  [N];
    logic [ADDR_W-1:0] ad_arr  [N];
    logic [TAG_W-1:0]  qa_arr  [N];
    logic [TAG_W-1:0]  qb_arr  [N];

    rs_pick_lowest #(.N(N)) u_alloc_pick (
        .req(free_vec), .gnt(alloc_gnt), .idx(alloc_idx), .any(iss_ready)
    );

    rs_pick_lowest #(.N(N)) u_disp_pick (
        .req(ready_vec), .gnt(disp_gnt), .idx(disp_idx), .any(disp_valid)
    );

    for (genvar g = 0; g < N; g++) begin : g_slot
        rs_slot #(
            .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
            .MY_TAG(TAG_W'(BASE_TAG + g))
        ) u_slot (
            .clk(clk), .rst(rst),
            .alloc(iss_valid & alloc_gnt[g]),
            .iss_op(iss_op), .iss_tag_a(iss_tag_a), .iss_val_a(iss_val_a),
            .iss_tag_b(iss_tag_b), .iss_val_b(iss_val_b), .iss_addr(iss_addr),
            .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
            .grant(disp_gnt[g] & disp_ready),
            .is_free(free_vec[g]), .is_ready(ready_vec[g]),
            .op(op_arr[g]), .val_a(va_arr[g]), .val_b(vb_arr[g]), .addr(ad_arr[g]),
            .q_a(qa_arr[g]), .q_b(qb_arr[g])
        );
    end

    assign iss_tag_out = TAG_W'(BASE_TAG) + TAG_W'(alloc_idx);
    assign disp_tag    = TAG_W'(BASE_TAG) + TAG_W'(disp_idx);

    always_comb begin
        disp_op    = op_arr[disp_idx];
        disp_val_a = va_arr[disp_idx];
        disp_val_b = vb_arr[disp_idx];
        disp_addr  = ad_arr[disp_idx];
    end
endmodule

// File: rtl/rs_bank_checker.sv
module rs_bank_checker #(
    parameter int N     = 4,
    parameter int TAG_W = 3,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic             bus_valid,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic [IDX_W-1:0] disp_idx,
    input logic [N-1:0]     free_vec,
    input logic [TAG_W-1:0] qa_arr [N],
    input logic [TAG_W-1:0] qb_arr [N]
);
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (iss_ready && !disp_valid && free_vec == {N{1'b1}}));

    p_alloc_takes_one_r2: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready && !bus_valid) |=>
        ($countones(free_vec) == $past($countones(free_vec)) - 1));

    p_full_stays_full_r3: assert property (@(posedge clk) disable iff (rst)
        (!iss_ready && !bus_valid) |=> !iss_ready);

    p_offer_operands_present_r7: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> (qa_arr[disp_idx] == '0 && qb_arr[disp_idx] == '0));

    p_offer_held_r8: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !disp_ready) |=> disp_valid);

    p_free_needs_bus_r9: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> ($countones(free_vec) <= $past($countones(free_vec))));
endmodule

bind tag_station_bank rs_bank_checker #(.N(N), .TAG_W(TAG_W)) u_rs_chk (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .bus_valid(bus_valid), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_idx(disp_idx), .free_vec(free_vec), .qa_arr(qa_arr), .qb_arr(qb_arr)
);

// File: tb/tb_tag_station_bank.sv
`timescale 1ns/1ps
module tb_tag_station_bank;
    localparam int N = 4, OP_W = 4, TAG_W = 3, DATA_W = 16, ADDR_W = 16;

    logic clk = 1'b0;
    logic rst;
    logic iss_valid, iss_ready, bus_valid, disp_valid, disp_ready;
    logic [OP_W-1:0]   iss_op, disp_op;
    logic [TAG_W-1:0]  iss_tag_a, iss_tag_b, iss_tag_out, bus_tag, disp_tag;
    logic [DATA_W-1:0] iss_val_a, iss_val_b, bus_data, disp_val_a, disp_val_b;
    logic [ADDR_W-1:0] iss_addr, disp_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    tag_station_bank #(.N(N), .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W),
                       .ADDR_W(ADDR_W), .BASE_TAG(1)) dut (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_tag_a(iss_tag_a), .iss_val_a(iss_val_a), .iss_tag_b(iss_tag_b),
        .iss_val_b(iss_val_b), .iss_addr(iss_addr), .iss_ready(iss_ready),
        .iss_tag_out(iss_tag_out), .bus_valid(bus_valid), .bus_tag(bus_tag),
        .bus_data(bus_data), .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_tag(disp_tag), .disp_op(disp_op), .disp_val_a(disp_val_a),
        .disp_val_b(disp_val_b), .disp_addr(disp_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // advance one edge; inputs change and outputs are sampled at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        iss_valid = 0; iss_op = '0; iss_tag_a = '0; iss_val_a = '0;
        iss_tag_b = '0; iss_val_b = '0; iss_addr = '0;
        bus_valid = 0; bus_tag = '0; bus_data = '0; disp_ready = 0;
    endtask

    task automatic issue(input logic [3:0] op, input logic [2:0] ta, input logic [15:0] va,
                         input logic [2:0] tb, input logic [15:0] vb, input logic [15:0] ad);
        iss_valid = 1; iss_op = op; iss_tag_a = ta; iss_val_a = va;
        iss_tag_b = tb; iss_val_b = vb; iss_addr = ad;
        tick();
        iss_valid = 0;
    endtask

    task automatic broadcast(input logic [2:0] t, input logic [15:0] d);
        bus_valid = 1; bus_tag = t; bus_data = d;
        tick();
        bus_valid = 0;
    endtask

    task automatic take_and_retire(input logic [2:0] t);
        chk("R8 offered tag before take", {29'd0, disp_tag}, {29'd0, t});
        disp_ready = 1;
        tick();
        disp_ready = 0;
        broadcast(t, 16'h0);
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1;
        tick();
        tick();
        rst = 0;
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 iss_ready after reset", {31'd0, iss_ready}, 32'd1);
        chk("R1 iss_tag_out after reset", {29'd0, iss_tag_out}, 32'd1);
        chk("R1 disp_valid after reset", {31'd0, disp_valid}, 32'd0);
    endtask

    task automatic t_ready_issue();
        issue(4'h3, 3'd0, 16'h0011, 3'd0, 16'h0022, 16'h0040);
        chk("R4 offered next cycle", {31'd0, disp_valid}, 32'd1);
        chk("R4 disp_tag", {29'd0, disp_tag}, 32'd1);
        chk("R4 disp_op", {28'd0, disp_op}, 32'h3);
        chk("R4 disp_val_a", {16'd0, disp_val_a}, 32'h11);
        chk("R4 disp_val_b", {16'd0, disp_val_b}, 32'h22);
        chk("R4 disp_addr", {16'd0, disp_addr}, 32'h40);
        chk("R2 next free tag", {29'd0, iss_tag_out}, 32'd2);
        disp_ready = 1;
        tick();
        disp_ready = 0;
        chk("R8 not offered after take", {31'd0, disp_valid}, 32'd0);
        chk("R9 still occupied before own tag", {29'd0, iss_tag_out}, 32'd2);
        broadcast(3'd1, 16'h0);
        chk("R9 free after own tag", {29'd0, iss_tag_out}, 32'd1);
    endtask

    task automatic t_wakeup();
        issue(4'h5, 3'd5, 16'hFFFF, 3'd0, 16'h0007, 16'h0);
        chk("R5 waits for tag", {31'd0, disp_valid}, 32'd0);
        broadcast(3'd6, 16'h0099);
        chk("R5 other tag ignored", {31'd0, disp_valid}, 32'd0);
        broadcast(3'd5, 16'h00AB);
        chk("R5 woken", {31'd0, disp_valid}, 32'd1);
        chk("R5 captured value", {16'd0, disp_val_a}, 32'hAB);
        chk("R5 given value kept", {16'd0, disp_val_b}, 32'h7);
        take_and_retire(3'd1);
    endtask

    task automatic t_same_cycle();
        bus_valid = 1; bus_tag = 3'd6; bus_data = 16'h0055;
        issue(4'h1, 3'd0, 16'h0001, 3'd6, 16'hFFFF, 16'h0);
        bus_valid = 0;
        chk("R6 captured at issue", {31'd0, disp_valid}, 32'd1);
        chk("R6 value", {16'd0, disp_val_b}, 32'h55);
        take_and_retire(3'd1);
    endtask

    task automatic t_priority();
        for (int i = 1; i <= 3; i++) issue(4'h2, 3'd7, 16'h0, 3'd0, 16'(i), 16'h0);
        chk("R7 none ready", {31'd0, disp_valid}, 32'd0);
        broadcast(3'd7, 16'h0070);
        chk("R7 lowest first", {29'd0, disp_tag}, 32'd1);
        chk("R7 lowest value", {16'd0, disp_val_b}, 32'h1);
        tick();
        chk("R8 offer held without take", {29'd0, disp_tag}, 32'd1);
        disp_ready = 1;
        tick();
        chk("R7 second", {29'd0, disp_tag}, 32'd2);
        chk("R7 second value", {16'd0, disp_val_b}, 32'h2);
        tick();
        chk("R7 third", {29'd0, disp_tag}, 32'd3);
        chk("R7 woken value", {16'd0, disp_val_a}, 32'h70);
        tick();
        disp_ready = 0;
        chk("R7 one per cycle, drained", {31'd0, disp_valid}, 32'd0);
        for (int i = 1; i <= 3; i++) broadcast(3'(i), 16'h0);
        chk("R9 all freed", {31'd0, iss_ready}, 32'd1);
    endtask

    task automatic t_full();
        for (int i = 1; i <= 4; i++) issue(4'h4, 3'd7, 16'h0, 3'd0, 16'(16'h10 + i), 16'h0);
        chk("R3 iss_ready low when full", {31'd0, iss_ready}, 32'd0);
        issue(4'h9, 3'd0, 16'h00EE, 3'd0, 16'h00EE, 16'h0);
        issue(4'h9, 3'd0, 16'h00EE, 3'd0, 16'h00EE, 16'h0);
        chk("R3 blocked issue not offered", {31'd0, disp_valid}, 32'd0);
        broadcast(3'd7, 16'h0001);
        disp_ready = 1;
        for (int i = 1; i <= 4; i++) begin
            chk("R3 original slot offered", {29'd0, disp_tag}, 32'(i));
            chk("R3 original value kept", {16'd0, disp_val_b}, 32'(16'h10 + i));
            tick();
        end
        disp_ready = 0;
        chk("R3 no extra slot", {31'd0, disp_valid}, 32'd0);
        for (int i = 1; i <= 4; i++) broadcast(3'(i), 16'h0);
    endtask

    task automatic t_reset_mid();
        issue(4'h6, 3'd7, 16'h0, 3'd0, 16'h0, 16'h0);
        issue(4'h6, 3'd0, 16'h0, 3'd7, 16'h0, 16'h0);
        do_reset();
        chk("R10 all free", {31'd0, iss_ready}, 32'd1);
        chk("R10 lowest tag", {29'd0, iss_tag_out}, 32'd1);
        broadcast(3'd7, 16'h1234);
        chk("R10 no wakeup after reset", {31'd0, disp_valid}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        @(negedge clk);
        t_reset();
        t_ready_issue();
        t_wakeup();
        t_same_cycle();
        t_priority();
        t_full();
        t_reset_mid();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule